// File: doc/BRIEF.md
# Pin Function and Output Level Controller

This block manages 54 general-purpose pins from a simple 32-bit register bus. Each pin carries a 3-bit function code, and each pin has a stored level bit. Software sets and clears stored levels through separate write-one-to-set and write-one-to-clear registers. An output line is driven for every pin. An output line follows the level only for pins whose function code marks them as outputs, and only when a set or clear write actually changes the stored level.

The function codes of pins 48 to 53 also steer a routing select between two SD host interfaces. The select is sticky. It moves to the second host when all six pins hold code 4. It moves back to the first host when all six hold code 0. Any other combination leaves it where it is. Event detection, interrupt enables and pull control occupy part of the register window, but those registers do nothing. The bus is a single-cycle request with valid, write, a 12-bit byte address and write data. Read data comes back one cycle later.

Top module: `gpio_fsel_ctrl`

## Requirements
- R1: Function codes are packed ten per word in six function words at byte offsets 0x00 to 0x14. Pin n is held in word n/10, bits [3*(n%10)+2 : 3*(n%10)]. Writing a function word updates the codes and reading it returns them.
- R2: In a function word, bits 31:30 read as zero. In word 5 (offset 0x14), bits 31:12 hold no pin, so writes to them are dropped and they read as zero.
- R3: A write to 0x1C (pins 0..31) or 0x20 (pins 32..53) sets the stored level of every pin whose data bit is 1. A write to 0x28 or 0x2C clears it in the same way. Data bits that are 0 leave levels unchanged. In the upper bank, bits 31:22 are ignored.
- R4: Reading 0x34 returns the stored levels of pins 0..31. Reading 0x38 returns pins 32..53 in bits 21:0, with bits 31:22 as zero. Writes to these two offsets change nothing.
- R5: For a pin with function code 1, a set that raises its stored level drives its output line high, and a clear that lowers it drives the line low. The line changes at the clock edge of the write.
- R6: A pin without code 1 keeps its output line unchanged, while its stored level still updates. A set or clear that leaves the stored level unchanged does not touch the output line, even for an output pin.
- R7: The set and clear registers read as zero.
- R8: Offsets 0x40 to 0x9C and every other undefined offset in the 4 KiB window ignore writes and read as zero.
- R9: The SD select (0 = first host, 1 = second host) becomes 1 when, after a function-word write, pins 48..53 all hold code 4. It becomes 0 when they all hold code 0. Otherwise it keeps its value. It changes at the clock edge of the write.
- R10: After reset, all function codes, stored levels and output lines are 0, and the SD select is 0.
- R11: Read data appears on the read-data port in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window (bits 1:0 ignored) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_out | output | 54 | Output line of each pin |
| sd_host_sel | output | 1 | SD routing select: 0 first host, 1 second host |

## Verification
The hardest state to reach is a pin whose output line disagrees with its stored level. To get there, the level is set while the pin is not an output, and the pin is switched to output afterwards. A later set must then leave the line low, and only a clear followed by a set may raise it. Directed steps build this case on one pin. Random traffic then mixes function writes biased toward codes 0, 1 and 4 with set and clear bursts, so the same divergence appears on many pins. The sticky SD select needs six fields spread across two words to agree. The stimulus therefore often writes the two words back to back with matching codes, and a directed step checks that the half-updated mixed state leaves the select unchanged.

// File: rtl/gpio_fs_pkg.sv
package gpio_fs_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned FN_W   = 3;

  localparam logic [FN_W-1:0] FN_OUTPUT = 3'd1;
  localparam logic [FN_W-1:0] FN_SD_A   = 3'd0;
  localparam logic [FN_W-1:0] FN_SD_B   = 3'd4;

  // word indices (byte offset / 4)
  localparam logic [WORD_W-1:0] WI_SET0 = WORD_W'(7);
  localparam logic [WORD_W-1:0] WI_CLR0 = WORD_W'(10);
  localparam logic [WORD_W-1:0] WI_LEV0 = WORD_W'(13);
endpackage

// File: rtl/gpio_fn_regs.sv
module gpio_fn_regs
  import gpio_fs_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned FPW      = 10,
  localparam int unsigned NW      = (NUM_PINS + FPW - 1) / FPW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [WORD_W-1:0]         wr_word,
  input  logic [BUS_W-1:0]          wr_data,
  output logic [NUM_PINS*FN_W-1:0]  fn_q,
  output logic [NUM_PINS*FN_W-1:0]  fn_d,
  output logic [NW*BUS_W-1:0]       rd_flat
);
  always_comb begin
    fn_d = fn_q;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (wr_en && (wr_word == WORD_W'(p / FPW)))
        fn_d[p*FN_W +: FN_W] = wr_data[(p % FPW)*FN_W +: FN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fn_q <= '0;
    else if (wr_en) fn_q <= fn_d;
  end

  always_comb begin
    rd_flat = '0;
    for (int p = 0; p < NUM_PINS; p++)
      rd_flat[(p / FPW)*BUS_W + (p % FPW)*FN_W +: FN_W] = fn_q[p*FN_W +: FN_W];
  end

  // a word that is not written keeps its fields
  assert_word_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word == '0) |=> $stable(rd_flat[NW*BUS_W-1:BUS_W]));
endmodule

// File: rtl/gpio_level_bank.sv
module gpio_level_bank
  import gpio_fs_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  localparam int unsigned NB      = (NUM_PINS + BUS_W - 1) / BUS_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      set_en,
  input  logic                      clr_en,
  input  logic [WORD_W-1:0]         bank_idx,
  input  logic [BUS_W-1:0]          wr_data,
  input  logic [NUM_PINS*FN_W-1:0]  fn_q,
  output logic [NUM_PINS-1:0]       lev_q,
  output logic [NUM_PINS-1:0]       out_q,
  output logic [NB*BUS_W-1:0]       rd_flat
);
  logic [NUM_PINS-1:0] hit, is_out, lev_d, out_d;
  logic                upd_en;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign hit[p]    = wr_data[p % BUS_W] && (bank_idx == WORD_W'(p / BUS_W));
    assign is_out[p] = (fn_q[p*FN_W +: FN_W] == FN_OUTPUT);

    assert_nonout_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !is_out[p] |=> $stable(out_q[p]));
    assert_rise_on_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_q[p]) |-> (lev_q[p] && !$past(lev_q[p])));
    assert_fall_on_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_q[p]) |-> (!lev_q[p] && $past(lev_q[p])));
  end

  always_comb begin
    lev_d = lev_q;
    out_d = out_q;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (set_en && hit[p]) begin
        lev_d[p] = 1'b1;
        if (is_out[p] && !lev_q[p]) out_d[p] = 1'b1;
      end
      if (clr_en && hit[p]) begin
        lev_d[p] = 1'b0;
        if (is_out[p] && lev_q[p]) out_d[p] = 1'b0;
      end
    end
  end

  assign upd_en = set_en | clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lev_q <= '0;
      out_q <= '0;
    end else if (upd_en) begin
      lev_q <= lev_d;
      out_q <= out_d;
    end
  end

  always_comb begin
    rd_flat = '0;
    rd_flat[NUM_PINS-1:0] = lev_q;
  end
endmodule

// File: rtl/gpio_sd_route.sv
module gpio_sd_route
  import gpio_fs_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 54,
  parameter int unsigned SD_FIRST  = 48,
  parameter int unsigned SD_COUNT  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fs_wr,
  input  logic [NUM_PINS*FN_W-1:0]  fn_next,
  input  logic [NUM_PINS*FN_W-1:0]  fn_q,
  output logic                      sel_q
);
  logic all_a, all_b, now_b, now_a, sel_d;

  always_comb begin
    all_a = 1'b1;
    all_b = 1'b1;
    now_a = 1'b1;
    now_b = 1'b1;
    for (int i = SD_FIRST; i < SD_FIRST + SD_COUNT; i++) begin
      all_a &= (fn_next[i*FN_W +: FN_W] == FN_SD_A);
      all_b &= (fn_next[i*FN_W +: FN_W] == FN_SD_B);
      now_a &= (fn_q[i*FN_W +: FN_W] == FN_SD_A);
      now_b &= (fn_q[i*FN_W +: FN_W] == FN_SD_B);
    end
  end

  always_comb begin
    sel_d = sel_q;
    if (all_a)      sel_d = 1'b0;
    else if (all_b) sel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= 1'b0;
    else if (fs_wr) sel_q <= sel_d;
  end

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_wr |=> $stable(sel_q));
  assert_rise_needs_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> now_b);
  assert_fall_needs_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_q) |-> now_a);
endmodule

// File: rtl/gpio_fsel_ctrl.sv
module gpio_fsel_ctrl
  import gpio_fs_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned FPW      = 10,
  parameter int unsigned SD_FIRST = 48,
  parameter int unsigned SD_COUNT = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [11:0]          req_addr,
  input  logic [31:0]          req_wdata,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic                 sd_host_sel
);
  localparam int unsigned NW = (NUM_PINS + FPW - 1) / FPW;
  localparam int unsigned NB = (NUM_PINS + BUS_W - 1) / BUS_W;

  logic [WORD_W-1:0]         word;
  logic                      is_fs, is_set, is_clr, wr, rd;
  logic                      fs_wr, set_en, clr_en;
  logic [WORD_W-1:0]         bank_idx;
  logic [NUM_PINS*FN_W-1:0]  fn_q, fn_d;
  logic [NW*BUS_W-1:0]       fs_rd;
  logic [NB*BUS_W-1:0]       lev_rd;
  logic [NUM_PINS-1:0]       lev_q;
  logic [BUS_W-1:0]          rd_d, rdata_q;

  assign word   = req_addr[ADDR_W-1:2];
  assign wr     = req_valid &&  req_write;
  assign rd     = req_valid && !req_write;
  assign is_fs  = (word < WORD_W'(NW));
  assign is_set = (word >= WI_SET0) && (word < WI_SET0 + WORD_W'(NB));
  assign is_clr = (word >= WI_CLR0) && (word < WI_CLR0 + WORD_W'(NB));
  assign fs_wr  = wr && is_fs;
  assign set_en = wr && is_set;
  assign clr_en = wr && is_clr;
  assign bank_idx = is_set ? (word - WI_SET0) : (word - WI_CLR0);

  gpio_fn_regs #(.NUM_PINS(NUM_PINS), .FPW(FPW)) u_fn (
    .clk(clk), .rst_n(rst_n), .wr_en(fs_wr), .wr_word(word),
    .wr_data(req_wdata), .fn_q(fn_q), .fn_d(fn_d), .rd_flat(fs_rd)
  );

  gpio_level_bank #(.NUM_PINS(NUM_PINS)) u_lev (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .clr_en(clr_en),
    .bank_idx(bank_idx), .wr_data(req_wdata), .fn_q(fn_q),
    .lev_q(lev_q), .out_q(pin_out), .rd_flat(lev_rd)
  );

  gpio_sd_route #(.NUM_PINS(NUM_PINS), .SD_FIRST(SD_FIRST), .SD_COUNT(SD_COUNT)) u_sd (
    .clk(clk), .rst_n(rst_n), .fs_wr(fs_wr), .fn_next(fn_d), .fn_q(fn_q),
    .sel_q(sd_host_sel)
  );

  always_comb begin
    rd_d = '0;
    for (int w = 0; w < NW; w++)
      if (word == WORD_W'(w)) rd_d = fs_rd[w*BUS_W +: BUS_W];
    for (int b = 0; b < NB; b++)
      if (word == WI_LEV0 + WORD_W'(b)) rd_d = lev_rd[b*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rd_d;
  end

  assign rsp_rdata = rdata_q;

  assert_setclr_rd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (is_set || is_clr)) |=> (rsp_rdata == '0));
  assert_fs_top_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && is_fs) |=> (rsp_rdata[31:30] == 2'b00));
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rsp_rdata));
  assert_inert_rd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && word >= WORD_W'(16)) |=> (rsp_rdata == '0));
endmodule

// File: tb/tb_gpio_fsel_ctrl.sv
module tb_gpio_fsel_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;
  logic [53:0] pin_out;
  logic        sd_host_sel;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [2:0]  m_fn [54];
  logic [53:0] m_lev, m_out;
  logic        m_sd;

  always #10 clk = ~clk;

  gpio_fsel_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .pin_out(pin_out), .sd_host_sel(sd_host_sel)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [9:0]  w = a[11:2];
    logic [31:0] v = '0;
    if (w < 10'd6) begin
      for (int i = 0; i < 10; i++)
        if (w*10 + i < 54) v[3*i +: 3] = m_fn[w*10 + i];
    end else if (w == 10'd13) v = m_lev[31:0];
    else if (w == 10'd14) v = {10'b0, m_lev[53:32]};
    return v;
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    logic [9:0] w = a[11:2];
    if (w < 10'd6) return (w == 10'd5) ? "R2" : "R1";
    if (w == 10'd7 || w == 10'd8 || w == 10'd10 || w == 10'd11) return "R7";
    if (w == 10'd13 || w == 10'd14) return "R4";
    return "R8";
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    logic [9:0] w = a[11:2];
    if (w < 10'd6) begin
      logic a0 = 1'b1, b4 = 1'b1;
      for (int i = 0; i < 10; i++)
        if (w*10 + i < 54) m_fn[w*10 + i] = d[3*i +: 3];
      for (int p = 48; p < 54; p++) begin
        a0 &= (m_fn[p] == 3'd0);
        b4 &= (m_fn[p] == 3'd4);
      end
      if (a0) m_sd = 1'b0;
      else if (b4) m_sd = 1'b1;
    end else if (w == 10'd7 || w == 10'd8 || w == 10'd10 || w == 10'd11) begin
      int  base = (w == 10'd8 || w == 10'd11) ? 32 : 0;
      bit  setw = (w == 10'd7 || w == 10'd8);
      for (int i = 0; i < 32; i++) begin
        int p = base + i;
        if (p < 54 && d[i]) begin
          if (setw) begin
            if (!m_lev[p] && m_fn[p] == 3'd1) m_out[p] = 1'b1;
            m_lev[p] = 1'b1;
          end else begin
            if (m_lev[p] && m_fn[p] == 3'd1) m_out[p] = 1'b0;
            m_lev[p] = 1'b0;
          end
        end
      end
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    model_write(a, d);
    chk({tag, " pin_out"}, {10'b0, pin_out}, {10'b0, m_out});
    chk({tag, " sd_sel"}, {63'b0, sd_host_sel}, {63'b0, m_sd});
  endtask

  task automatic bus_rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = $urandom;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " read"}, {32'b0, rsp_rdata}, {32'b0, exp_read(a)});
  endtask

  function automatic logic [2:0] pick_code();
    case ($urandom % 4)
      0: return 3'd0;
      1: return 3'd1;
      2: return 3'd4;
      default: return 3'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F0C5EED));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    for (int p = 0; p < 54; p++) m_fn[p] = 3'd0;
    m_lev = '0; m_out = '0; m_sd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk("R10 pin_out", {10'b0, pin_out}, 64'd0);
    chk("R10 sd_sel", {63'b0, sd_host_sel}, 64'd0);
    bus_rd(12'h000, "R10");
    bus_rd(12'h034, "R10");

    // R1 / R2 layout and dead bits
    bus_wr(12'h000, 32'hFFFF_FFFF, "R1");
    bus_rd(12'h000, "R1");
    bus_wr(12'h014, 32'hFFFF_FFFF, "R2");
    bus_rd(12'h014, "R2");
    bus_wr(12'h008, 32'h2492_4924, "R1");
    bus_rd(12'h008, "R1");
    bus_wr(12'h000, 32'h0, "R1");
    bus_wr(12'h014, 32'h0, "R9");

    // R6: level set while pin 3 is an input, then pin made output
    bus_wr(12'h01C, 32'h0000_0008, "R6");
    bus_rd(12'h034, "R6");
    bus_wr(12'h000, 32'h0000_0200, "R6");
    bus_wr(12'h01C, 32'h0000_0008, "R6");
    chk("R6 pin3 stays low", {63'b0, pin_out[3]}, 64'd0);
    bus_wr(12'h028, 32'h0000_0008, "R6");
    bus_wr(12'h01C, 32'h0000_0008, "R5");
    chk("R5 pin3 high", {63'b0, pin_out[3]}, 64'd1);
    bus_wr(12'h028, 32'h0000_0008, "R5");
    chk("R5 pin3 low", {63'b0, pin_out[3]}, 64'd0);

    // R3 / R4 upper bank and ignored bits
    bus_wr(12'h020, 32'hFFFF_FFFF, "R3");
    bus_rd(12'h038, "R4");
    bus_wr(12'h038, 32'h0, "R4");
    bus_rd(12'h038, "R4");
    bus_wr(12'h02C, 32'h0000_0005, "R3");
    bus_rd(12'h038, "R3");
    bus_rd(12'h020, "R7");
    bus_rd(12'h028, "R7");

    // R8 inert and undefined offsets
    bus_wr(12'h04C, 32'hFFFF_FFFF, "R8");
    bus_rd(12'h04C, "R8");
    bus_wr(12'h018, 32'hFFFF_FFFF, "R8");
    bus_rd(12'h018, "R8");
    bus_rd(12'hFFC, "R8");

    // R9 sticky routing: mixed state must not switch
    bus_wr(12'h010, 32'h2400_0000, "R9");
    chk("R9 mixed keeps", {63'b0, sd_host_sel}, 64'd0);
    bus_wr(12'h014, 32'h0000_0924, "R9");
    chk("R9 all four", {63'b0, sd_host_sel}, 64'd1);
    bus_wr(12'h010, 32'h0, "R9");
    chk("R9 mixed holds", {63'b0, sd_host_sel}, 64'd1);
    bus_wr(12'h014, 32'h0, "R9");
    chk("R9 all zero", {63'b0, sd_host_sel}, 64'd0);

    // R11 read latency: old data before the edge, new after
    bus_rd(12'h034, "R11");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h038;
    chk("R11 before edge", {32'b0, rsp_rdata}, {32'b0, exp_read(12'h034)});
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 after edge", {32'b0, rsp_rdata}, {32'b0, exp_read(12'h038)});

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int k = $urandom % 10;
      if (k < 3) begin
        logic [31:0] d = '0;
        int w = $urandom % 6;
        for (int i = 0; i < 10; i++) d[3*i +: 3] = pick_code();
        d[31:30] = 2'($urandom);
        bus_wr(12'(w*4), d, "R1");
      end else if (k == 3) begin
        logic [2:0] c = ($urandom % 2) ? 3'd4 : 3'd0;
        logic [31:0] d4 = exp_read(12'h010);
        logic [31:0] d5 = exp_read(12'h014);
        d4[24 +: 3] = c; d4[27 +: 3] = c;
        for (int i = 0; i < 4; i++) d5[3*i +: 3] = c;
        bus_wr(12'h010, d4, "R9");
        bus_wr(12'h014, d5, "R9");
      end else if (k < 7) begin
        logic [11:0] a;
        case ($urandom % 4)
          0: a = 12'h01C; 1: a = 12'h020; 2: a = 12'h028; default: a = 12'h02C;
        endcase
        bus_wr(a, $urandom & $urandom, "R5");
      end else if (k == 7) begin
        bus_wr(12'(12'h040 + 4*($urandom % 24)), $urandom, "R8");
      end else begin
        logic [11:0] a;
        case ($urandom % 4)
          0: a = 12'(4*($urandom % 6));
          1: a = ($urandom % 2) ? 12'h034 : 12'h038;
          2: a = 12'(12'h01C + 4*($urandom % 5));
          default: a = 12'(4*($urandom % 1024));
        endcase
        bus_rd(a, tag_of(a));
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule